// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen transfers on its own, with no processor help between them. Each list slot holds three things: a word to send, a word that was received, and a command byte. The command byte sets four things for that slot:

- the levels driven on the four peripheral select lines;
- whether the selects stay active into the next slot;
- whether the transfer is the default 8 bits long or uses the programmed length;
- whether the lead delay and the trailing delay are programmed or standard.

Software first fills the transmit and command sections through a simple write port. It then gives a first-slot pointer and a last-slot pointer, and raises the enable. The controller walks the slots in order. Received words are written back into the list, where a read port can fetch them. The controller can loop back to slot 0 for as long as it stays enabled, or it can stop and raise a finished flag. A halt request parks it cleanly at the boundary between two slots. A low level on the slave-select sense input is flagged as a mode fault but does not stop the transfers.

Serial timing is fixed to clock-idle-low, sample-on-rising-edge, most significant bit first. MOSI changes only on falling SCK edges.

Top module: `qspi_queue_master`

## Requirements
- R1: Host port sections: 0 is transmit and 1 is command (low 8 bits); these two are written through the write port. Section 2 is receive. All three sections can be read at any time through the read port. After each transfer, the received word is stored in the receive section of that slot, right-justified with the unused upper bits zero.
- R2: Command byte layout: bit 7 continue, bit 6 length select, bit 5 programmed trailing delay, bit 4 programmed lead delay, bits 3:0 the levels driven on `pcs` for that slot. While SCK is high, `pcs` does not change.
- R3: With length select 0 a transfer is 8 bits. With length select 1 the length comes from `bits_code`: 0000 gives 16 bits, 1000 to 1111 give 8 to 15 bits, and the reserved codes 0001 to 0111 give 8 bits. Data goes out MSB first from the low bits of the transmit word. MOSI holds its value while SCK is high. MISO is sampled on each rising SCK edge.
- R4: SCK stays high for `baud` clocks and low for `baud` clocks, so its rate is the system clock divided by 2×`baud`. A `baud` of 0 acts as 1.
- R5: The time from the `pcs` change at the start of a slot to the first rising SCK edge is `lead_dly` clocks if the lead bit is set, otherwise `baud` clocks. A value of 0 acts as 1.
- R6: The time from the last falling SCK edge to the end of the slot is `trail_dly` clocks if the trailing bit is set, otherwise 17 clocks. A value of 0 acts as 1.
- R7: With continue clear, `pcs` returns to `cs_idle` for at least 2 clocks before the next slot. With continue set, `pcs` goes straight to the next slot's levels and never passes through idle.
- R8: When enabled and not finished, the controller starts at `new_ptr` and advances one slot at a time, wrapping from 15 to 0. It stops after `end_ptr`. If `loop_en` is set, it goes back to slot 0 after `end_ptr` and keeps going.
- R9: When the `end_ptr` slot completes with `loop_en` clear, `done_flag` is set and `busy` drops. The flag holds, and no new run starts, until `enable` is lowered.
- R10: A `halt_req` seen at the end of a slot stops the controller before the next slot. It sets `halt_ack` and keeps SCK low. Releasing the request clears `halt_ack`, and the controller continues with the next slot.
- R11: `ss_n` low while enabled sets `modf_flag`. The flag stays set until `enable` is lowered. It has no effect on the transfers.
- R12: Reset or lowering `enable` stops the controller at the next clock, whatever it is doing. This gives `busy` 0, SCK 0, `pcs` = `cs_idle`, and all flags clear.
- R13: `irq` equals `irq_en` AND (`halt_ack` OR `modf_flag`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low stops the controller and clears its flags |
| loop_en | input | 1 | Return to slot 0 after the last slot |
| halt_req | input | 1 | Halt at the next slot boundary |
| irq_en | input | 1 | Interrupt enable for halt and mode fault |
| baud | input | 8 | SCK half period in clocks |
| bits_code | input | 4 | Programmed transfer length code |
| lead_dly | input | 8 | Programmed select-to-SCK delay |
| trail_dly | input | 8 | Programmed delay after the transfer |
| new_ptr | input | 4 | First slot of the run |
| end_ptr | input | 4 | Last slot of the run |
| cs_idle | input | 4 | Idle levels of the select lines |
| ram_we | input | 1 | Host list write strobe |
| ram_wsect | input | 2 | Write section (0 transmit, 1 command) |
| ram_waddr | input | 4 | Write slot |
| ram_wdata | input | 16 | Write data |
| ram_rsect | input | 2 | Read section (0 transmit, 1 command, 2 receive) |
| ram_raddr | input | 4 | Read slot |
| ram_rdata | output | 16 | Read data, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select sense input for mode fault |
| pcs | output | 4 | Peripheral select lines |
| busy | output | 1 | Controller active or halted |
| cur_ptr | output | 4 | Slot being processed |
| done_flag | output | 1 | Run finished |
| halt_ack | output | 1 | Halted at a slot boundary |
| modf_flag | output | 1 | Mode fault seen |
| irq | output | 1 | Interrupt request |

## Verification
The list of slots is seen through `pcs`. A wrong slot pointer makes the select pattern or the MOSI word of the very next slot wrong, so it shows up in the next segment on the wire. A wrong length counter shows up in the count of SCK rising edges, and a wrong delay counter shows up as an edge that is off by whole clocks. Each of these is caught within the slot where it happens. A wrong receive path shows up one slot later, when the receive section is read back and compared with the inverted-loopback value.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_LEAD, S_SHIFT, S_TRAIL, S_NEXT, S_HALT
    } seq_state_e;

    localparam logic [1:0] SECT_TX  = 2'd0;
    localparam logic [1:0] SECT_CMD = 2'd1;
    localparam logic [1:0] SECT_RX  = 2'd2;
endpackage

// File: rtl/qspi_queue_ram.sv
module qspi_queue_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 16,
    parameter int CMD_W  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [1:0]        host_wsect,
    input  logic [PTR_W-1:0]  host_waddr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [1:0]        host_rsect,
    input  logic [PTR_W-1:0]  host_raddr,
    output logic [WORD_W-1:0] host_rdata,
    input  logic [PTR_W-1:0]  eng_addr,
    output logic [WORD_W-1:0] eng_tx,
    output logic [CMD_W-1:0]  eng_cmd,
    input  logic              eng_rx_we,
    input  logic [WORD_W-1:0] eng_rx_data
);
    import qspi_pkg::*;

    logic [WORD_W-1:0] tx_mem [DEPTH];
    logic [CMD_W-1:0]  cmd_mem[DEPTH];
    logic [WORD_W-1:0] rx_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (host_we && host_wsect == SECT_TX)  tx_mem[host_waddr]  <= host_wdata;
        if (host_we && host_wsect == SECT_CMD) cmd_mem[host_waddr] <= host_wdata[CMD_W-1:0];
        if (eng_rx_we)                         rx_mem[eng_addr]    <= eng_rx_data;
    end

    always_comb begin
        eng_tx  = tx_mem[eng_addr];
        eng_cmd = cmd_mem[eng_addr];
        unique case (host_rsect)
            SECT_TX:  host_rdata = tx_mem[host_raddr];
            SECT_CMD: host_rdata = WORD_W'(cmd_mem[host_raddr]);
            SECT_RX:  host_rdata = rx_mem[host_raddr];
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qspi_len_decode.sv
module qspi_len_decode #(
    parameter int WORD_W = 16,
    localparam int LEN_W = $clog2(WORD_W + 1)
) (
    input  logic             use_code,
    input  logic [3:0]       code,
    output logic [LEN_W-1:0] nbits
);
    localparam int BASE = 8;

    always_comb begin
        if (!use_code)         nbits = LEN_W'(BASE);
        else if (code == 4'd0) nbits = LEN_W'(WORD_W);
        else if (code[3])      nbits = LEN_W'(BASE) + LEN_W'(code[2:0]);
        else                   nbits = LEN_W'(BASE);
    end
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master #(
    parameter int DEPTH     = 16,
    parameter int WORD_W    = 16,
    parameter int CS_W      = 4,
    parameter int CNT_W     = 8,
    parameter int STD_TRAIL = 17,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              loop_en,
    input  logic              halt_req,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  baud,
    input  logic [3:0]        bits_code,
    input  logic [CNT_W-1:0]  lead_dly,
    input  logic [CNT_W-1:0]  trail_dly,
    input  logic [PTR_W-1:0]  new_ptr,
    input  logic [PTR_W-1:0]  end_ptr,
    input  logic [CS_W-1:0]   cs_idle,
    input  logic              ram_we,
    input  logic [1:0]        ram_wsect,
    input  logic [PTR_W-1:0]  ram_waddr,
    input  logic [WORD_W-1:0] ram_wdata,
    input  logic [1:0]        ram_rsect,
    input  logic [PTR_W-1:0]  ram_raddr,
    output logic [WORD_W-1:0] ram_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    input  logic              ss_n,
    output logic [CS_W-1:0]   pcs,
    output logic              busy,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic              done_flag,
    output logic              halt_ack,
    output logic              modf_flag,
    output logic              irq
);
    import qspi_pkg::*;

    localparam int LEN_W  = $clog2(WORD_W + 1);
    localparam int CMD_W  = CS_W + 4;
    localparam int B_CONT = CS_W + 3;
    localparam int B_WSEL = CS_W + 2;
    localparam int B_POST = CS_W + 1;
    localparam int B_PRE  = CS_W;

    typedef struct packed {
        seq_state_e        st;
        logic [PTR_W-1:0]  ptr;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  bitn;
        logic              sck;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [CS_W-1:0]   pcs;
        logic [CMD_W-1:0]  cmd;
        logic              done;
        logic              hack;
        logic              modf;
    } seq_t;

    seq_t q, d;

    logic [WORD_W-1:0] slot_tx;
    logic [CMD_W-1:0]  slot_cmd;
    logic [LEN_W-1:0]  slot_len;
    logic              rx_we;

    qspi_queue_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CMD_W(CMD_W)) ram_i (
        .clk(clk), .host_we(ram_we), .host_wsect(ram_wsect), .host_waddr(ram_waddr),
        .host_wdata(ram_wdata), .host_rsect(ram_rsect), .host_raddr(ram_raddr),
        .host_rdata(ram_rdata), .eng_addr(q.ptr), .eng_tx(slot_tx), .eng_cmd(slot_cmd),
        .eng_rx_we(rx_we), .eng_rx_data(q.rx_sh)
    );

    qspi_len_decode #(.WORD_W(WORD_W)) len_i (
        .use_code(slot_cmd[B_WSEL]), .code(bits_code), .nbits(slot_len)
    );

    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_comb begin
        d     = q;
        rx_we = 1'b0;
        if (!ss_n) d.modf = 1'b1;
        unique case (q.st)
            S_IDLE: begin
                d.pcs = cs_idle;
                d.sck = 1'b0;
                if (!q.done) begin
                    d.ptr = new_ptr;
                    d.st  = S_LOAD;
                end
            end
            S_LOAD: begin
                d.cmd   = slot_cmd;
                d.pcs   = slot_cmd[CS_W-1:0];
                d.tx_sh = slot_tx << (LEN_W'(WORD_W) - slot_len);
                d.rx_sh = '0;
                d.bitn  = slot_len - 1'b1;
                d.cnt   = slot_cmd[B_PRE] ? span(lead_dly) : span(baud);
                d.st    = S_LEAD;
            end
            S_LEAD: begin
                if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
                else begin
                    d.sck   = 1'b1;
                    d.rx_sh = {q.rx_sh[WORD_W-2:0], miso};
                    d.cnt   = span(baud);
                    d.st    = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
                else if (q.sck) begin
                    d.sck = 1'b0;
                    if (q.bitn == '0) begin
                        rx_we = 1'b1;
                        d.cnt = q.cmd[B_POST] ? span(trail_dly) : CNT_W'(STD_TRAIL - 1);
                        d.st  = S_TRAIL;
                    end else begin
                        d.tx_sh = q.tx_sh << 1;
                        d.bitn  = q.bitn - 1'b1;
                        d.cnt   = span(baud);
                    end
                end else begin
                    d.sck   = 1'b1;
                    d.rx_sh = {q.rx_sh[WORD_W-2:0], miso};
                    d.cnt   = span(baud);
                end
            end
            S_TRAIL: begin
                if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
                else begin
                    if (!q.cmd[B_CONT]) d.pcs = cs_idle;
                    d.st = S_NEXT;
                end
            end
            S_NEXT: begin
                if (q.ptr == end_ptr && !loop_en) begin
                    d.done = 1'b1;
                    d.pcs  = cs_idle;
                    d.st   = S_IDLE;
                end else begin
                    d.ptr = (q.ptr == end_ptr) ? '0 : q.ptr + 1'b1;
                    if (halt_req) begin
                        d.hack = 1'b1;
                        d.st   = S_HALT;
                    end else begin
                        d.st = S_LOAD;
                    end
                end
            end
            S_HALT: begin
                if (!halt_req) begin
                    d.hack = 1'b0;
                    d.st   = S_LOAD;
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (!enable) begin
            d.st   = S_IDLE;
            d.sck  = 1'b0;
            d.pcs  = cs_idle;
            d.done = 1'b0;
            d.hack = 1'b0;
            d.modf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.pcs   <= '1;
        end else begin
            q <= d;
        end
    end

    assign sck       = q.sck;
    assign mosi      = q.tx_sh[WORD_W-1];
    assign pcs       = q.pcs;
    assign busy      = (q.st != S_IDLE);
    assign cur_ptr   = q.ptr;
    assign done_flag = q.done;
    assign halt_ack  = q.hack;
    assign modf_flag = q.modf;
    assign irq       = irq_en & (q.hack | q.modf);
endmodule

// File: rtl/qspi_queue_master_chk.sv
module qspi_queue_master_chk #(
    parameter int CS_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            sck,
    input logic            mosi,
    input logic [CS_W-1:0] pcs,
    input logic            busy,
    input logic            done_flag,
    input logic            halt_ack,
    input logic            modf_flag
);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !halt_ack));

    assert_disable_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !sck && !done_flag && !modf_flag));

    assert_halt_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ack |-> (!sck && busy));

    assert_done_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !busy);

    assert_modf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && modf_flag) |=> modf_flag);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sck && $past(sck)) |-> $stable(mosi));

    assert_pcs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sck) |-> $stable(pcs));
endmodule

bind qspi_queue_master qspi_queue_master_chk #(.CS_W(CS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sck(sck), .mosi(mosi), .pcs(pcs),
    .busy(busy), .done_flag(done_flag), .halt_ack(halt_ack), .modf_flag(modf_flag)
);

// File: tb/qspi_queue_master_tb.sv
module qspi_queue_master_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        enable = 0, loop_en = 0, halt_req = 0, irq_en = 0;
    logic [7:0]  baud = 8'd2, lead_dly = 8'd1, trail_dly = 8'd1;
    logic [3:0]  bits_code = 4'd0, new_ptr = 0, end_ptr = 0, cs_idle = 4'hF;
    logic        ram_we = 0;
    logic [1:0]  ram_wsect = 0, ram_rsect = 0;
    logic [3:0]  ram_waddr = 0, ram_raddr = 0;
    logic [15:0] ram_wdata = 0, ram_rdata;
    logic        sck, mosi, miso, ss_n = 1;
    logic [3:0]  pcs, cur_ptr;
    logic        busy, done_flag, halt_ack, modf_flag, irq;

    assign miso = ~mosi;   // inverted loopback slave

    qspi_queue_master dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .loop_en(loop_en), .halt_req(halt_req),
        .irq_en(irq_en), .baud(baud), .bits_code(bits_code), .lead_dly(lead_dly),
        .trail_dly(trail_dly), .new_ptr(new_ptr), .end_ptr(end_ptr), .cs_idle(cs_idle),
        .ram_we(ram_we), .ram_wsect(ram_wsect), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_rsect(ram_rsect), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .pcs(pcs), .busy(busy),
        .cur_ptr(cur_ptr), .done_flag(done_flag), .halt_ack(halt_ack),
        .modf_flag(modf_flag), .irq(irq)
    );

    always #4 clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // wire monitor: one segment per non-idle pcs pattern
    int cyc = 0, nseg = 0;
    bit seg_open = 0, prev_sck = 0;
    logic [3:0] prev_pcs = 4'hF;
    int seg_cs[64], seg_n[64], seg_d[64], seg_t0[64], seg_rise[64], seg_ffall[64],
        seg_lfall[64], seg_close[64];

    always @(negedge clk) begin
        cyc++;
        if (pcs !== prev_pcs) begin
            if (seg_open) begin seg_close[nseg-1] = cyc; seg_open = 0; end
            if (pcs != cs_idle && nseg < 64) begin
                seg_cs[nseg] = pcs; seg_t0[nseg] = cyc; seg_n[nseg] = 0; seg_d[nseg] = 0;
                seg_rise[nseg] = -1; seg_ffall[nseg] = -1; seg_close[nseg] = -1;
                nseg++; seg_open = 1;
            end
        end
        if (seg_open && sck && !prev_sck) begin
            if (seg_n[nseg-1] == 0) seg_rise[nseg-1] = cyc;
            seg_n[nseg-1]++;
            seg_d[nseg-1] = ((seg_d[nseg-1] << 1) | int'(mosi)) & 32'hFFFF;
        end
        if (seg_open && !sck && prev_sck) begin
            if (seg_ffall[nseg-1] < 0) seg_ffall[nseg-1] = cyc;
            seg_lfall[nseg-1] = cyc;
        end
        prev_sck = sck;
        prev_pcs = pcs;
    end

    function automatic int exp_len(bit ws, bit [3:0] c);
        if (!ws) return 8;
        if (c == 4'd0) return 16;
        if (c[3]) return 8 + int'(c[2:0]);
        return 8;
    endfunction
    function automatic int lmask(int n); return (1 << n) - 1; endfunction
    function automatic int at_least1(int v); return (v == 0) ? 1 : v; endfunction

    task automatic wr(input logic [1:0] s, input int a, input int v);
        @(negedge clk);
        ram_we = 1; ram_wsect = s; ram_waddr = a[3:0]; ram_wdata = v[15:0];
        @(negedge clk);
        ram_we = 0;
    endtask

    task automatic rd(input logic [1:0] s, input int a, output int v);
        @(negedge clk);
        ram_rsect = s; ram_raddr = a[3:0];
        #1 v = int'(ram_rdata);
    endtask

    task automatic stop_run();
        @(negedge clk); enable = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int np, input int ep, input string req);
        int t;
        @(negedge clk);
        nseg = 0; new_ptr = np[3:0]; end_ptr = ep[3:0]; enable = 1;
        t = 0;
        while (!done_flag && t < 40000) begin @(negedge clk); t++; end
        #1 check({req, " done"}, int'(done_flag && !busy), 1);
    endtask

    int txv[16], cmdv[16], v;

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        check("R12 reset busy", int'(busy), 0);
        check("R12 reset sck", int'(sck), 0);
        check("R12 reset pcs", int'(pcs), 'hF);
        check("R12 reset flags", int'({done_flag, halt_ack, modf_flag}), 0);

        // R3 R1: every length code, single slot
        for (int c = 0; c < 16; c++) begin
            int tx, n;
            tx = int'($urandom() & 32'hFFFF);
            wr(2'd0, 0, tx);
            wr(2'd1, 0, 'h4E);   // length select set, cs 1110
            bits_code = c[3:0]; baud = 8'd1;
            run(0, 0, "R3");
            n = exp_len(1'b1, c[3:0]);
            check($sformatf("R3 code %0d bit count", c), seg_n[0], n);
            check($sformatf("R3 code %0d mosi word", c), seg_d[0], tx & lmask(n));
            rd(2'd2, 0, v);
            check($sformatf("R1 code %0d receive word", c), v, (~tx) & lmask(n));
            stop_run();
        end

        // R2 R4 R5 R6 R7 R8 R1: random slots 3..14, continue clear
        baud = 8'd1 + 8'($urandom_range(2)); lead_dly = 8'd4; trail_dly = 8'd3;
        bits_code = 4'b1011;
        for (int i = 3; i <= 14; i++) begin
            txv[i]  = int'($urandom() & 32'hFFFF);
            cmdv[i] = int'(($urandom() & 32'h70)) | i;
            wr(2'd0, i, txv[i]);
            wr(2'd1, i, cmdv[i]);
        end
        rd(2'd1, 7, v);
        check("R1 command readback", v, cmdv[7]);
        run(3, 14, "R8");
        check("R8 slot count", nseg, 12);
        for (int k = 0; k < 12; k++) begin
            int i, n;
            i = k + 3;
            n = exp_len(cmdv[i][6], bits_code);
            check($sformatf("R2 R8 slot %0d pcs", i), seg_cs[k], i);
            check($sformatf("R3 slot %0d bit count", i), seg_n[k], n);
            check($sformatf("R3 slot %0d mosi", i), seg_d[k], txv[i] & lmask(n));
            check($sformatf("R5 slot %0d lead", i), seg_rise[k] - seg_t0[k],
                  cmdv[i][4] ? 4 : int'(baud));
            check($sformatf("R6 slot %0d trail", i), seg_close[k] - seg_lfall[k],
                  cmdv[i][5] ? 3 : 17);
            check($sformatf("R4 slot %0d half period", i), seg_ffall[k] - seg_rise[k], int'(baud));
            if (k > 0)
                check($sformatf("R7 slot %0d idle gap", i),
                      int'(seg_t0[k] - seg_close[k-1] >= 2), 1);
            rd(2'd2, i, v);
            check($sformatf("R1 slot %0d rx", i), v, (~txv[i]) & lmask(n));
        end
        // R9: stays finished while enabled
        repeat (100) @(negedge clk);
        #1 check("R9 no restart", nseg, 12);
        check("R9 flag held", int'(done_flag), 1);
        stop_run();
        check("R12 flag cleared", int'(done_flag), 0);

        // R7: continue set, distinct patterns 0xA,0xB,0xC
        baud = 8'd2;
        for (int i = 0; i < 3; i++) begin
            wr(2'd0, i, 'h5A + i);
            wr(2'd1, i, 'h80 | (10 + i));
        end
        run(0, 2, "R7");
        check("R7 slot count", nseg, 3);
        check("R7 no gap 0-1", seg_t0[1] - seg_close[0], 0);
        check("R7 no gap 1-2", seg_t0[2] - seg_close[1], 0);
        check("R7 third pcs", seg_cs[2], 'hC);
        stop_run();

        // R8 loop, R10 halt, R13, R12 mid-transfer stop
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, i, 'h1234 * (i + 1));
            wr(2'd1, i, i + 1);
        end
        loop_en = 1; irq_en = 1;
        @(negedge clk);
        nseg = 0; new_ptr = 4'd2; end_ptr = 4'd3; enable = 1;
        begin
            int t;
            t = 0;
            while (nseg < 6 && t < 20000) begin @(negedge clk); t++; end
            halt_req = 1;
            t = 0;
            while (!halt_ack && t < 20000) begin @(negedge clk); t++; end
        end
        #1 check("R10 halted count", nseg, 6);
        check("R8 loop order 2", seg_cs[2], 1);
        check("R8 loop order 3", seg_cs[3], 2);
        check("R8 loop order 5", seg_cs[5], 4);
        check("R13 irq on halt", int'(irq), 1);
        repeat (40) @(negedge clk);
        #1 check("R10 parked", nseg, 6);
        check("R10 sck low", int'(sck), 0);
        halt_req = 0;
        begin
            int t;
            t = 0;
            while (nseg < 7 && t < 20000) begin @(negedge clk); t++; end
        end
        #1 check("R10 resume slot", seg_cs[6], 1);
        check("R10 ack cleared", int'(halt_ack), 0);
        while (!sck) @(negedge clk);
        enable = 0;
        @(negedge clk); #1;
        check("R12 stop busy", int'(busy), 0);
        check("R12 stop sck", int'(sck), 0);
        check("R12 stop pcs", int'(pcs), 'hF);
        loop_en = 0;
        repeat (3) @(negedge clk);

        // R11 R13: mode fault has no effect on transfers
        irq_en = 0;
        @(negedge clk);
        nseg = 0; new_ptr = 0; end_ptr = 1; enable = 1; ss_n = 0;
        repeat (3) @(negedge clk);
        ss_n = 1;
        #1 check("R11 flag set", int'(modf_flag), 1);
        check("R13 irq masked", int'(irq), 0);
        irq_en = 1;
        #1 check("R13 irq modf", int'(irq), 1);
        begin
            int t;
            t = 0;
            while (!done_flag && t < 20000) begin @(negedge clk); t++; end
        end
        #1 check("R11 run completes", nseg, 2);
        check("R11 data intact", seg_d[1], 'h2468 & 'hFF);
        check("R11 sticky", int'(modf_flag), 1);
        stop_run();
        check("R11 cleared", int'(modf_flag), 0);

        summary();
    end
endmodule